// File: doc/BRIEF.md
# Path Remote Defect Indication Code Generator

This block produces the three-bit remote defect field carried in the path status byte for up to `NCH` STS-1 channels. Each channel's field is taken either from a software value or from the block's own hardware generation. The hardware path looks at the channel's path defect flags (AIS, LOP, PLM and UNEQ), removes any defect that the inhibit mask suppresses, and ranks what remains. It then encodes the result in one of two ways: a legacy form that stays compatible with the older single-bit scheme, or an enhanced three-bit form that tells server, connectivity and payload faults apart.

Each channel runs a small state machine with two states, `ST_CLEAR` and `ST_HOLD`, and a frame counter. The machine acts only on frame strobes. Arm (`ST_CLEAR` to `ST_HOLD`) happens when a defect shows at a strobe. While in `ST_HOLD`, the machine follows one of four transitions at each strobe. Refresh applies when a defect of equal or higher rank is present: that rank is taken and the counter is reloaded. Count applies when only a lower rank or no defect is present: the counter steps down. Handover applies when the counter has run out and a lower-ranked defect is present: that rank is adopted with a fresh hold. Release (`ST_HOLD` to `ST_CLEAR`) applies when the counter has run out and no defect is present. As a result, any asserted code lasts at least `HOLD_FRAMES` frames.

In single-channel (STM-1) mode only channel 0 is driven, and the other channels send 000.

Top module: `path_rdi_gen`

## Requirements
- R1: After reset, every channel outputs 000 until the first frame strobe.
- R2: When `sw_mode` is 1, each channel i outputs `sw_code[3i+2:3i]` combinationally, whatever its defects are.
- R3: When `stm1_mode` is 1, channels 1 and up output 000 in both software and hardware operation, and channel 0 is unaffected. When `stm1_mode` is cleared, the other channels show their codes again.
- R4: In legacy mode (`enh_mode`=0), the hardware code is 100 when an uninhibited AIS or LOP is held, and 000 otherwise. PLM and UNEQ have no effect in this mode.
- R5: In enhanced mode (`enh_mode`=1), the hardware code follows this priority: AIS or LOP gives 101, otherwise UNEQ gives 110, otherwise PLM gives 010, and no defect gives 001.
- R6: `inh_mask` bit 0 suppresses AIS, bit 1 suppresses LOP, bit 2 suppresses PLM and bit 3 suppresses UNEQ. A suppressed defect is treated as absent.
- R7: The hardware code changes only at the clock edge where `frame_tick` is sampled high. It reflects the defects and mode sampled at that edge.
- R8: A hardware code asserted at a strobe stays in place through the next `HOLD_FRAMES`-1 strobes (default 20 frames in total), even if its defect is gone. It changes at the `HOLD_FRAMES`-th strobe.
- R9: A defect of the held rank that is present at a strobe restarts the full hold.
- R10: A higher-ranked defect replaces a held lower code at the same strobe and restarts the hold.
- R11: When a hold runs out, a lower-ranked defect still present is adopted with a new hold. If no defect is present, the no-defect code is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame |
| sw_mode | input | 1 | 1 selects software codes for all channels |
| enh_mode | input | 1 | 1 selects enhanced coding, 0 selects legacy coding |
| stm1_mode | input | 1 | 1 drives channel 0 only |
| sw_code | input | 3*NCH | Software codes, channel i at bits 3i+2:3i |
| ais_def | input | NCH | Path AIS defect per channel |
| lop_def | input | NCH | Loss of pointer defect per channel |
| plm_def | input | NCH | Payload label mismatch defect per channel |
| uneq_def | input | NCH | Unequipped defect per channel |
| inh_mask | input | 4 | Per-defect inhibit, bit order AIS, LOP, PLM, UNEQ |
| rdi_code | output | 3*NCH | Outgoing codes, channel i at bits 3i+2:3i |

## Verification
The assertions check on every cycle the behaviours that depend only on one cycle or on a pair of adjacent cycles. These are the software pass-through, the silencing of the upper channels in STM-1 mode, the legacy code keeping its low bits clear, the enhanced code never being zero, a server defect producing the server code right after a strobe, and the output staying still between strobes. The frame-long behaviours can only be shown by the bench's scenarios, because each of them spans many strobes: the 20-frame hold, the reload, the upgrade to a higher rank, and the handover to a lower rank at expiry. The same applies to the full priority table under inhibit masks.

// File: rtl/rdi_pkg.sv
package rdi_pkg;

    localparam int CODE_W = 3;

    // defect rank, higher value wins
    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_PAY  = 2'd1,
        LV_CONN = 2'd2,
        LV_SRV  = 2'd3
    } lvl_t;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_HOLD  = 1'b1
    } hold_st_t;

    function automatic logic [CODE_W-1:0] rdi_encode(input lvl_t lvl, input logic enh);
        logic [CODE_W-1:0] c;
        if (!enh) begin
            c = (lvl == LV_SRV) ? 3'b100 : 3'b000;
        end else begin
            unique case (lvl)
                LV_SRV:  c = 3'b101;
                LV_CONN: c = 3'b110;
                LV_PAY:  c = 3'b010;
                default: c = 3'b001;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/rdi_defect_rank.sv
module rdi_defect_rank
    import rdi_pkg::*;
(
    input  logic       ais,
    input  logic       lop,
    input  logic       plm,
    input  logic       uneq,
    input  logic [3:0] inh,
    input  logic       enh,
    output lvl_t       rank
);
    logic srv_act, conn_act, pay_act;

    always_comb begin
        srv_act  = (ais & ~inh[0]) | (lop & ~inh[1]);
        pay_act  = enh & plm  & ~inh[2];
        conn_act = enh & uneq & ~inh[3];
        if (srv_act)       rank = LV_SRV;
        else if (conn_act) rank = LV_CONN;
        else if (pay_act)  rank = LV_PAY;
        else               rank = LV_NONE;
    end
endmodule

// File: rtl/rdi_hold_fsm.sv
module rdi_hold_fsm
    import rdi_pkg::*;
#(
    parameter int HOLD_FRAMES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              enh,
    input  lvl_t              rank_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W = ($clog2(HOLD_FRAMES) > 0) ? $clog2(HOLD_FRAMES) : 1;
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_FRAMES - 1);

    hold_st_t          st_q, st_n;
    lvl_t              held_q, held_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [CODE_W-1:0] code_q, code_n;

    // next-state logic, acts only on frame strobes
    always_comb begin
        st_n   = st_q;
        held_n = held_q;
        cnt_n  = cnt_q;
        code_n = code_q;
        if (frame_tick) begin
            unique case (st_q)
                ST_CLEAR: begin
                    if (rank_i != LV_NONE) begin      // arm
                        st_n   = ST_HOLD;
                        held_n = rank_i;
                        cnt_n  = HOLD_LOAD;
                    end else begin
                        held_n = LV_NONE;
                    end
                end
                ST_HOLD: begin
                    if (rank_i != LV_NONE && rank_i >= held_q) begin   // refresh
                        held_n = rank_i;
                        cnt_n  = HOLD_LOAD;
                    end else if (cnt_q != '0) begin                     // count
                        cnt_n  = cnt_q - 1'b1;
                    end else if (rank_i != LV_NONE) begin               // handover
                        held_n = rank_i;
                        cnt_n  = HOLD_LOAD;
                    end else begin                                      // release
                        st_n   = ST_CLEAR;
                        held_n = LV_NONE;
                    end
                end
                default: st_n = ST_CLEAR;
            endcase
            code_n = rdi_encode(held_n, enh);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_CLEAR;
            held_q <= LV_NONE;
            cnt_q  <= '0;
            code_q <= '0;
        end else begin
            st_q   <= st_n;
            held_q <= held_n;
            cnt_q  <= cnt_n;
            code_q <= code_n;
        end
    end

    // outputs
    always_comb begin
        code_o = code_q;
    end
endmodule

// File: rtl/path_rdi_gen.sv
module path_rdi_gen
    import rdi_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int HOLD_FRAMES = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_tick,
    input  logic                  sw_mode,
    input  logic                  enh_mode,
    input  logic                  stm1_mode,
    input  logic [CODE_W*NCH-1:0] sw_code,
    input  logic [NCH-1:0]        ais_def,
    input  logic [NCH-1:0]        lop_def,
    input  logic [NCH-1:0]        plm_def,
    input  logic [NCH-1:0]        uneq_def,
    input  logic [3:0]            inh_mask,
    output logic [CODE_W*NCH-1:0] rdi_code
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvl_t              rank;
        logic [CODE_W-1:0] hw_code;

        rdi_defect_rank u_rank (
            .ais  (ais_def[c]),
            .lop  (lop_def[c]),
            .plm  (plm_def[c]),
            .uneq (uneq_def[c]),
            .inh  (inh_mask),
            .enh  (enh_mode),
            .rank (rank)
        );

        rdi_hold_fsm #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_tick (frame_tick),
            .enh        (enh_mode),
            .rank_i     (rank),
            .code_o     (hw_code)
        );

        if (c == 0) begin : g_first
            assign rdi_code[CODE_W*c +: CODE_W] =
                sw_mode ? sw_code[CODE_W*c +: CODE_W] : hw_code;
        end else begin : g_rest
            assign rdi_code[CODE_W*c +: CODE_W] = stm1_mode ? '0 :
                (sw_mode ? sw_code[CODE_W*c +: CODE_W] : hw_code);
        end
    end
endmodule

// File: rtl/rdi_gen_chk.sv
module rdi_gen_chk #(
    parameter int NCH = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_tick,
    input logic               sw_mode,
    input logic               enh_mode,
    input logic               stm1_mode,
    input logic [3*NCH-1:0]   sw_code,
    input logic [NCH-1:0]     ais_def,
    input logic [NCH-1:0]     lop_def,
    input logic [3:0]         inh_mask,
    input logic [3*NCH-1:0]   rdi_code
);
    // R7: no change between strobes while hardware-driven
    assert_quiet_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !sw_mode && $stable(stm1_mode))
        |=> (sw_mode || !$stable(stm1_mode) || $stable(rdi_code)));

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R2: software value reaches the line
        assert_sw_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sw_mode |-> (rdi_code[3*c +: 3] == sw_code[3*c +: 3]) || (stm1_mode && c != 0));

        // R3: upper channels silent in single-channel mode
        if (c != 0) begin : g_up
            assert_stm1_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
                stm1_mode |-> rdi_code[3*c +: 3] == 3'b000);
        end

        // R4: legacy code never uses the two low bits
        assert_legacy_lowbits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_tick && !sw_mode && !enh_mode)
            |=> (sw_mode || rdi_code[3*c +: 2] == 2'b00));

        // R5: enhanced code is never all zero
        assert_enh_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_tick && !sw_mode && enh_mode)
            |=> (sw_mode || (stm1_mode && c != 0) || rdi_code[3*c +: 3] != 3'b000));

        // R5: uninhibited server defect gives the server code right away
        assert_server_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_tick && !sw_mode && enh_mode &&
             ((ais_def[c] && !inh_mask[0]) || (lop_def[c] && !inh_mask[1])))
            |=> (sw_mode || (stm1_mode && c != 0) || rdi_code[3*c +: 3] == 3'b101));
    end
endmodule

bind path_rdi_gen rdi_gen_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .sw_mode    (sw_mode),
    .enh_mode   (enh_mode),
    .stm1_mode  (stm1_mode),
    .sw_code    (sw_code),
    .ais_def    (ais_def),
    .lop_def    (lop_def),
    .inh_mask   (inh_mask),
    .rdi_code   (rdi_code)
);

// File: tb/path_rdi_gen_tb.sv
`timescale 1ns/1ps
module path_rdi_gen_tb;
    localparam int NCH = 3;
    localparam int NV  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       sw_mode = 1'b0;
    logic       enh_mode = 1'b1;
    logic       stm1_mode = 1'b0;
    logic [8:0] sw_code = '0;
    logic [2:0] ais_def = '0, lop_def = '0, plm_def = '0, uneq_def = '0;
    logic [3:0] inh_mask = '0;
    logic [8:0] rdi_code;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    path_rdi_gen #(.NCH(NCH), .HOLD_FRAMES(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sw_mode(sw_mode),
        .enh_mode(enh_mode), .stm1_mode(stm1_mode), .sw_code(sw_code),
        .ais_def(ais_def), .lop_def(lop_def), .plm_def(plm_def),
        .uneq_def(uneq_def), .inh_mask(inh_mask), .rdi_code(rdi_code)
    );

    // {enh, ais, lop, plm, uneq, inh, expected ch2/ch1/ch0 in octal}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 3'b001, 3'b000, 3'b010, 3'b100, 4'b0000, 9'o625},
        {1'b0, 3'b001, 3'b000, 3'b010, 3'b100, 4'b0000, 9'o004},
        {1'b1, 3'b000, 3'b010, 3'b111, 3'b000, 4'b0000, 9'o252},
        {1'b1, 3'b000, 3'b010, 3'b111, 3'b000, 4'b0010, 9'o222},
        {1'b1, 3'b111, 3'b000, 3'b000, 3'b111, 4'b0001, 9'o666},
        {1'b1, 3'b111, 3'b000, 3'b000, 3'b111, 4'b1001, 9'o111},
        {1'b0, 3'b000, 3'b111, 3'b000, 3'b000, 4'b0000, 9'o444},
        {1'b0, 3'b000, 3'b000, 3'b111, 3'b111, 4'b0000, 9'o000},
        {1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 4'b0000, 9'o111},
        {1'b1, 3'b000, 3'b000, 3'b110, 3'b011, 4'b0000, 9'o266}
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%o expected=%o", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // strobe, then sample on the following falling edge
    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // table walk: R4 R5 R6 priority, masks and legacy ignore
        for (int v = 0; v < NV; v++) begin
            do_reset();
            enh_mode = VEC[v][25];
            ais_def  = VEC[v][24:22];
            lop_def  = VEC[v][21:19];
            plm_def  = VEC[v][18:16];
            uneq_def = VEC[v][15:13];
            inh_mask = VEC[v][12:9];
            tick();
            check($sformatf("R4 R5 R6 vector %0d", v), rdi_code, VEC[v][8:0]);
        end
        ais_def = '0; lop_def = '0; plm_def = '0; uneq_def = '0; inh_mask = '0;

        // R1 reset state, R7 frame-bound update
        enh_mode = 1'b1;
        ais_def = 3'b111;
        do_reset();
        check("R1 reset output", rdi_code, 9'o000);
        ais_def = 3'b000;
        tick();
        check("R7 first strobe", rdi_code, 9'o111);
        ais_def = 3'b001;
        repeat (3) @(negedge clk);
        check("R7 no change before strobe", rdi_code, 9'o111);
        tick();
        check("R7 change at strobe", rdi_code, 9'o115);

        // R8 hold length
        ais_def = 3'b000;
        tick_n(19);
        check("R8 held through 19 strobes", rdi_code, 9'o115);
        tick();
        check("R8 released at 20th strobe", rdi_code, 9'o111);

        // R9 reload
        ais_def = 3'b001; tick();
        ais_def = 3'b000; tick_n(10);
        ais_def = 3'b001; tick();
        ais_def = 3'b000; tick_n(19);
        check("R9 hold restarted", rdi_code, 9'o115);
        tick();
        check("R9 release after restart", rdi_code, 9'o111);

        // R10 upgrade
        plm_def = 3'b001; tick();
        check("R10 payload code", rdi_code, 9'o112);
        plm_def = 3'b000; ais_def = 3'b001; tick();
        check("R10 server replaces payload", rdi_code, 9'o115);

        // R11 handover to lower rank, then release
        ais_def = 3'b000; plm_def = 3'b001;
        tick_n(19);
        check("R11 lower rank waits", rdi_code, 9'o115);
        tick();
        check("R11 lower rank adopted", rdi_code, 9'o112);
        plm_def = 3'b000;
        tick_n(19);
        check("R11 adopted code held", rdi_code, 9'o112);
        tick();
        check("R11 cleared", rdi_code, 9'o111);

        // R8 in legacy mode
        enh_mode = 1'b0;
        do_reset();
        lop_def = 3'b001; tick();
        check("R4 legacy server", rdi_code, 9'o004);
        lop_def = 3'b000;
        tick_n(19);
        check("R8 legacy hold", rdi_code, 9'o004);
        tick();
        check("R8 legacy release", rdi_code, 9'o000);

        // R2 software insert
        sw_mode = 1'b1; sw_code = 9'o357; ais_def = 3'b111;
        @(negedge clk);
        check("R2 software codes", rdi_code, 9'o357);
        tick();
        check("R2 strobe ignored", rdi_code, 9'o357);

        // R3 single-channel mode
        stm1_mode = 1'b1;
        @(negedge clk);
        check("R3 software single channel", rdi_code, 9'o007);
        sw_mode = 1'b0; enh_mode = 1'b1;
        tick();
        check("R3 hardware single channel", rdi_code, 9'o005);
        stm1_mode = 1'b0;
        @(negedge clk);
        check("R3 channels restored", rdi_code, 9'o555);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule